// File: doc/BRIEF.md
# Word-Parallel Pipelined Distributed Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter built without multipliers. It accepts one two's-complement sample per clock. It looks at every bit position of the sample history in the same cycle, and it produces one filtered result per clock after a fixed latency. For each bit position there is a private copy of a small precomputed table. Each table entry holds the sum of the coefficients selected by one pattern of that bit across a group of taps. The table outputs are shifted by their bit weight, the sign-bit slice is negated, and a registered binary adder tree sums them.

Each table is addressed by a group of `GROUP` taps. This keeps the table depth at 2^GROUP entries for any tap count. A filter with `TAPS` taps therefore uses ceil(TAPS/GROUP) tables per bit position, and all of their outputs feed the same tree. The coefficients are a packed parameter vector. A sample is taken when `in_valid` is high, and each result is marked by `out_valid`.

Top module: `da_fir_par`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `out_valid` is low and `out_data` is zero. Reset clears the whole sample history, so the results after reset treat every earlier sample as zero.
- R2: Each result equals sum over k = 0..TAPS-1 of c_k * x_(n-k). Here c_k is the two's-complement field `COEFS[k*COEF_W +: COEF_W]`, x_n is the most recently accepted sample, and tap 0 pairs with that newest sample. A table addressed with all-zero bits returns zero on the next clock.
- R3: A sample accepted at a rising edge has its result on `out_data`, with `out_valid` high, right after the rising edge LAT-1 edges later. LAT = 2 + ceil(log2(SAMPLE_W * ceil(TAPS/GROUP))), which is 7 for the defaults.
- R4: With `in_valid` high on every clock, a result is produced on every clock. Every accepted sample gives exactly one result, results come out in acceptance order, and `out_valid` never rises without a matching sample.
- R5: A cycle with `in_valid` low does not move the sample history and produces no result.
- R6: Samples and coefficients are two's complement. The most negative sample -2^(SAMPLE_W-1), paired with the most negative coefficient, gives an exact product. The top bit slice is weighted by -2^(SAMPLE_W-1).
- R7: `out_data` is COEF_W + SAMPLE_W + ceil(log2(TAPS)) bits wide. It holds every result exactly, and no adder in the tree overflows.
- R8: TAPS need not be a multiple of GROUP. Missing taps in the last group behave as zero coefficients, and a 3-tap filter with GROUP = 2 and the 16-tap default both meet R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | SAMPLE_W | Two's-complement sample |
| out_valid | output | 1 | Result strobe, registered |
| out_data | output | OUT_W | Two's-complement filtered result, registered |

## Verification
The hardest case to reach is the extreme of the sign slice. The negated top-bit term must dominate the sum while every tap holds the most negative sample or the most positive one against large coefficients of both signs. Only a long unbroken run of full-scale samples fills the whole history that way, and at that point every tree level carries its largest magnitude. The stimulus therefore opens with long runs of -128, +127 and an alternation of the two. These runs are followed by gap-free random data, by random data with idle gaps that must freeze the history, and by a reset in the middle of the stream. A single 3-tap instance with two groups of two taps covers the padded last group.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  // number of registered adder levels for n leaves, never less than one
  function automatic int tree_levels(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/da_fir_rom.sv
// One partial-sum table: entry a holds the sum of the coefficients whose
// tap bit is set in a. Registered read, suited to block RAM inference.
module da_fir_rom #(
  parameter int G  = 4,
  parameter int CW = 8,
  parameter int PW = CW + $clog2(G) + 1,
  parameter logic [G*CW-1:0] COEFS = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [G-1:0]         addr,
  output logic signed [PW-1:0] rd_data
);
  localparam int DEPTH = 1 << G;

  logic signed [PW-1:0] mem [DEPTH];
  logic signed [PW-1:0] fill;

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      fill = '0;
      for (int t = 0; t < G; t++)
        if (a[t]) fill = fill + PW'($signed(COEFS[t*CW +: CW]));
      mem[a] = fill;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= mem[addr];
  end

  // R2: no selected tap means a zero partial sum
  a_r2_zero_addr: assert property (@(posedge clk) disable iff (rst)
    addr == '0 |=> rd_data == '0);

endmodule

// File: rtl/da_fir_tree.sv
// Registered binary adder tree over 2**L signed leaves.
module da_fir_tree #(
  parameter int L = 3,
  parameter int W = 20
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [(1<<L)*W-1:0]   leaves,
  output logic signed [W-1:0]   root
);
  localparam int NP = 1 << L;
  localparam int HALF = NP / 2;

  logic signed [W-1:0] lvl [1:L][HALF];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int lv = 1; lv <= L; lv++)
        for (int i = 0; i < HALF; i++) lvl[lv][i] <= '0;
    end else begin
      for (int i = 0; i < HALF; i++)
        lvl[1][i] <= $signed(leaves[(2*i)*W +: W]) + $signed(leaves[(2*i+1)*W +: W]);
      for (int lv = 2; lv <= L; lv++)
        for (int i = 0; i < (NP >> lv); i++)
          lvl[lv][i] <= lvl[lv-1][2*i] + lvl[lv-1][2*i+1];
    end
  end

  assign root = lvl[L][0];

  function automatic logic sum_fits(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W:0] s;
    s = {x[W-1], x} + {y[W-1], y};
    return s[W] == s[W-1];
  endfunction

  // R7: every pairwise addition stays inside the accumulator width
  always_ff @(posedge clk) begin
    if (!rst) begin
      for (int i = 0; i < HALF; i++)
        a_r7_no_overflow: assert (sum_fits(leaves[(2*i)*W +: W], leaves[(2*i+1)*W +: W]));
      for (int lv = 2; lv <= L; lv++)
        for (int i = 0; i < (NP >> lv); i++)
          a_r7_no_overflow_lvl: assert (sum_fits(lvl[lv-1][2*i], lvl[lv-1][2*i+1]));
    end
  end

endmodule

// File: rtl/da_fir_par.sv
module da_fir_par
  import da_fir_pkg::*;
#(
  parameter int TAPS     = 16,
  parameter int SAMPLE_W = 8,
  parameter int COEF_W   = 8,
  parameter int GROUP    = 4,
  parameter logic [TAPS*COEF_W-1:0] COEFS = {
    8'h80, 8'h7f, 8'h05, 8'hfb, 8'h10, 8'he3, 8'h01, 8'h40,
    8'hc0, 8'h22, 8'h99, 8'h0c, 8'h7f, 8'h80, 8'h3a, 8'hf1},
  localparam int OUT_W = COEF_W + SAMPLE_W + $clog2(TAPS)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [SAMPLE_W-1:0] in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_data
);
  localparam int NG  = ceil_div(TAPS, GROUP);
  localparam int TP  = NG * GROUP;
  localparam int PW  = COEF_W + $clog2(GROUP) + 1;
  localparam int NL  = SAMPLE_W * NG;
  localparam int L   = tree_levels(NL);
  localparam int NP  = 1 << L;
  localparam int LAT = 2 + L;
  localparam int PCW = $clog2(LAT + 1) + 1;
  localparam logic [TP*COEF_W-1:0] COEF_PAD = (TP*COEF_W)'(COEFS);

  // sample history, tap 0 newest
  logic signed [SAMPLE_W-1:0] win [TP];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < TP; i++) win[i] <= '0;
    end else if (in_valid) begin
      win[0] <= in_data;
      for (int i = 1; i < TP; i++) win[i] <= win[i-1];
    end
  end

  logic [NP*OUT_W-1:0] leaves;

  for (genvar b = 0; b < SAMPLE_W; b++) begin : g_bit
    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic [GROUP-1:0]      addr;
      logic signed [PW-1:0]  psum;

      always_comb
        for (int t = 0; t < GROUP; t++) addr[t] = win[g*GROUP + t][b];

      da_fir_rom #(
        .G(GROUP), .CW(COEF_W), .PW(PW),
        .COEFS(COEF_PAD[g*GROUP*COEF_W +: GROUP*COEF_W])
      ) u_rom (
        .clk(clk), .rst(rst), .addr(addr), .rd_data(psum)
      );

      if (b == SAMPLE_W - 1) begin : g_sign
        assign leaves[(b*NG+g)*OUT_W +: OUT_W] = -(OUT_W'(psum) <<< b);
      end else begin : g_mag
        assign leaves[(b*NG+g)*OUT_W +: OUT_W] = OUT_W'(psum) <<< b;
      end
    end
  end

  if (NP > NL) begin : g_pad
    assign leaves[NP*OUT_W-1 : NL*OUT_W] = '0;
  end

  da_fir_tree #(.L(L), .W(OUT_W)) u_tree (
    .clk(clk), .rst(rst), .leaves(leaves), .root(out_data)
  );

  logic [LAT-1:0] vpipe;
  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[LAT-2:0], in_valid};
  end
  assign out_valid = vpipe[LAT-1];

  // outstanding-sample count, kept for the checks below
  logic [PCW-1:0] pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + PCW'(in_valid) - PCW'(out_valid);
  end

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0));

  a_r4_result_has_sample: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> pend != '0);

  a_r3_bounded_in_flight: assert property (@(posedge clk) disable iff (rst)
    pend <= PCW'(LAT));

endmodule

// File: tb/da_fir_par_bench.sv
module da_fir_par_bench;
  localparam int SW = 8;
  localparam logic [16*8-1:0] C16 = {
    8'h80, 8'h7f, 8'h05, 8'hfb, 8'h10, 8'he3, 8'h01, 8'h40,
    8'hc0, 8'h22, 8'h99, 8'h0c, 8'h7f, 8'h80, 8'h3a, 8'hf1};
  localparam logic [3*8-1:0] C3 = {8'h80, 8'h7f, 8'hc3};
  localparam int LAT16 = 2 + $clog2(SW * 4);
  localparam int LAT3  = 2 + $clog2(SW * 2);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [SW-1:0] in_data = '0;
  logic ov16, ov3;
  logic signed [19:0] od16;
  logic signed [17:0] od3;

  always #5 clk = ~clk;

  da_fir_par #(.TAPS(16), .SAMPLE_W(SW), .COEF_W(8), .GROUP(4), .COEFS(C16)) u_da_fir_par (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov16), .out_data(od16));

  da_fir_par #(.TAPS(3), .SAMPLE_W(SW), .COEF_W(8), .GROUP(2), .COEFS(C3)) u_da_fir_par_t3 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(ov3), .out_data(od3));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  longint hist [16];
  longint qd [2][$];
  int     qc [2][$];
  int n_chk = 0;
  int n_bad = 0;
  string tag = "R2";
  logic done = 1'b0;

  function automatic longint coef(input int id, input int k);
    if (id == 0) return longint'($signed(C16[k*8 +: 8]));
    return longint'($signed(C3[k*8 +: 8]));
  endfunction

  function automatic longint ref_out(input int id);
    longint s = 0;
    int n = (id == 0) ? 16 : 3;
    for (int k = 0; k < n; k++) s += coef(id, k) * hist[k];
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input longint got, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d (cycle %0d)", req, got, exp, cyc);
    end
  endtask

  task automatic scan(input int id, input logic v, input longint d, input int lat, input string pfx);
    longint e;
    int c;
    if (v) begin
      if (qd[id].size() == 0) begin
        check(1'b0, {pfx, "R4 output without sample"}, d, 0);
      end else begin
        e = qd[id].pop_front();
        c = qc[id].pop_front();
        check(d == e, {pfx, tag}, d, e);
        check(cyc - c == lat - 1, {pfx, "R3 latency"}, cyc - c, lat - 1);
      end
    end else if (qd[id].size() > 0 && cyc - qc[id][0] > lat - 1) begin
      check(1'b0, {pfx, "R4 missing output"}, cyc - qc[id][0], lat - 1);
      void'(qd[id].pop_front());
      void'(qc[id].pop_front());
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d);
    @(negedge clk);
    scan(0, ov16, longint'(od16), LAT16, "");
    scan(1, ov3, longint'(od3), LAT3, "R8 ");
    in_valid = v;
    in_data  = d;
    if (v) begin
      for (int k = 15; k > 0; k--) hist[k] = hist[k-1];
      hist[0] = longint'($signed(d));
      for (int id = 0; id < 2; id++) begin
        qd[id].push_back(ref_out(id));
        qc[id].push_back(cyc + 1);
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(!ov16 && od16 == 0, "R1 reset outputs 16-tap", longint'(od16), 0);
    check(!ov3 && od3 == 0, "R1 reset outputs 3-tap", longint'(od3), 0);
    for (int k = 0; k < 16; k++) hist[k] = 0;
    for (int id = 0; id < 2; id++) begin
      qd[id].delete();
      qc[id].delete();
    end
    rst = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00);
  endtask

  function automatic logic [7:0] rnd_sample();
    return 8'($urandom_range(255, 0));
  endfunction

  initial begin
    void'($urandom(32'h00C0FFEE));
    for (int k = 0; k < 16; k++) hist[k] = 0;
    do_reset();

    // R6 / R7: full-scale runs fill every tap with extremes
    tag = "R6/R7 full-scale";
    for (int i = 0; i < 40; i++) step(1'b1, 8'h80);
    for (int i = 0; i < 40; i++) step(1'b1, 8'h7f);
    for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 8'h7f : 8'h80);

    // R4: unbroken random stream
    tag = "R4 back-to-back";
    for (int i = 0; i < 200; i++) step(1'b1, rnd_sample());

    // R5: after draining, idle cycles produce nothing
    idle(10);
    for (int i = 0; i < 5; i++) begin
      step(1'b0, rnd_sample());
      check(!ov16 && !ov3, "R5 idle output", longint'(ov16) + longint'(ov3), 0);
    end

    // R5: gapped stream, history frozen across gaps
    tag = "R5 gapped";
    for (int i = 0; i < 400; i++) step($urandom_range(9, 0) < 6, rnd_sample());
    idle(10);

    // R1: reset in mid-stream clears history
    for (int i = 0; i < 20; i++) step(1'b1, 8'h80);
    idle(10);
    do_reset();
    tag = "R1 history cleared";
    for (int i = 0; i < 5; i++) step(1'b1, rnd_sample());
    idle(10);

    // R2: impulse response, then long random stream
    tag = "R2 impulse";
    step(1'b1, 8'h01);
    for (int i = 0; i < 20; i++) step(1'b1, 8'h00);
    tag = "R2 random";
    for (int i = 0; i < 1500; i++) step($urandom_range(9, 0) < 9, rnd_sample());
    idle(12);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog expired got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule